// File: doc/BRIEF.md
# I2C Bus Timing and Timeout Timer

This block is a 10-bit timer placed next to an I2C controller. It has two jobs. It measures a short minimum time for each bus phase, and it acts as a watchdog that raises an interrupt when the bus stops moving. The timer advances only on cycles where the machine-cycle tick input is high. A tick arrives once per oscillator/12 period.

A run enable and three controller flags select one of four operating modes. The flags are slave enable, master request and master active.

| Mode | Run enable | Any flag set | Behaviour |
|---|---|---|---|
| Idle | 0 | no | Timer is held at zero |
| Free | 1 | no | Timer is a free-running time base that signals wrap-around |
| Slow | 0 | yes | Only the low three bits count, so a hang timeout is never raised |
| Bus | 1 | yes | All ten bits count. SCL edges and start/stop conditions clear the timer |

A 2-bit period code sets two values together: the minimum-time count and the timeout length.

Top module: `i2c_bus_timer`

## Requirements
- R1: In idle mode (run_en=0, slave_en=master_req=master_act=0) the count is held at zero. In this mode neither min_time_done nor a new timeout_irq is produced, however many ticks arrive.
- R2: In free mode (run_en=1, all flags 0) the timer counts every tick through all 10 bits. timeout_irq is set on the tick that wraps the count from 1023 to 0, which is the 1024th tick after a zero count. Bus events are ignored and min_time_done never pulses.
- R3: In slow mode (run_en=0, any flag 1) only count bits [2:0] advance, and they wrap from 7 to 0 without carry. Bits [9:3] hold. min_time_done still pulses, and timeout_irq is never set by counting.
- R4: In slow and bus modes, min_time_done pulses after the tick on which the low count reaches the minimum count. period_sel 2'b10, 2'b01, 2'b00 and 2'b11 give minimum counts of 7, 6, 5 and 4 ticks after a clear.
- R5: In bus mode, timeout_irq is set on the tick that would bring the count to the limit. period_sel 2'b10, 2'b01, 2'b00 and 2'b11 give limits of 1023, 1022, 1021 and 1020 ticks after a clear. That tick also restarts the count at zero and re-arms the minimum-time strobe.
- R6: min_time_done is high for exactly one clock cycle. It pulses at most once between two clears.
- R7: In slow and bus modes, a pulse on scl_edge, bus_start or bus_stop clears the count and re-arms the strobe. The clear wins over a tick in the same cycle.
- R8: The count changes only on cycles with tick high, except for clears.
- R9: timeout_irq stays set until irq_clr is pulsed. A set in the same cycle as irq_clr wins.
- R10: After reset, min_time_done and timeout_irq are 0 and the timer is in idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Machine-cycle advance enable |
| run_en | input | 1 | Timer run enable |
| slave_en | input | 1 | Controller slave enable flag |
| master_req | input | 1 | Controller master request flag |
| master_act | input | 1 | Controller master active flag |
| period_sel | input | 2 | Minimum-time and timeout code |
| scl_edge | input | 1 | Pulse on any SCL transition |
| bus_start | input | 1 | Pulse on a start condition |
| bus_stop | input | 1 | Pulse on a stop condition |
| irq_clr | input | 1 | Clears the timeout interrupt |
| min_time_done | output | 1 | One-cycle minimum-time strobe |
| timeout_irq | output | 1 | Sticky timeout / overflow interrupt |

## Verification
The bench sweeps all four period codes in bus mode and measures the exact tick at which the strobe and the interrupt appear. A swapped code table or an off-by-one limit therefore shows up as a wrong tick number. Slow mode runs well past 1024 ticks: a design that lets a carry reach the upper bits would raise a false timeout, and one without a re-arm guard would strobe on every wrap of the low bits. Clears driven together with a tick would expose a design that lets the tick win. A sparse tick pattern catches a counter that advances on every clock.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_FREE = 2'd1,
        MODE_SLOW = 2'd2,
        MODE_BUS  = 2'd3
    } tmode_e;

    // Rank of a period code: 0 gives the longest times, 3 the shortest.
    function automatic int unsigned sel_rank(input logic [1:0] sel);
        unique case (sel)
            2'b10:   return 0;
            2'b01:   return 1;
            2'b00:   return 2;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/i2ct_mode_dec.sv
module i2ct_mode_dec
    import i2ct_pkg::*;
(
    input  logic   run_en,
    input  logic   slave_en,
    input  logic   master_req,
    input  logic   master_act,
    output tmode_e mode
);
    logic any_flag;

    assign any_flag = slave_en | master_req | master_act;

    always_comb begin
        unique case ({any_flag, run_en})
            2'b00:   mode = MODE_IDLE;
            2'b01:   mode = MODE_FREE;
            2'b10:   mode = MODE_SLOW;
            default: mode = MODE_BUS;
        endcase
    end
endmodule

// File: rtl/i2ct_period_dec.sv
module i2ct_period_dec
    import i2ct_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int LOW_W  = 3,
    parameter int N_CODE = 4
) (
    input  logic [1:0]       period_sel,
    output logic [LOW_W-1:0] min_cnt,
    output logic [CNT_W-1:0] limit
);
    localparam int LIM_TOP = (1 << CNT_W) - 1;
    localparam int MIN_TOP = (1 << LOW_W) - 1;

    logic [CNT_W-1:0] lim_tab [N_CODE];
    logic [LOW_W-1:0] min_tab [N_CODE];

    for (genvar i = 0; i < N_CODE; i++) begin : g_tab
        assign lim_tab[i] = CNT_W'(LIM_TOP - i);
        assign min_tab[i] = LOW_W'(MIN_TOP - i);
    end

    logic [1:0] rank;
    assign rank    = 2'(sel_rank(period_sel));
    assign min_cnt = min_tab[rank];
    assign limit   = lim_tab[rank];
endmodule

// File: rtl/i2ct_core.sv
module i2ct_core
    import i2ct_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int LOW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tmode_e           mode,
    input  logic             bus_evt,
    input  logic             irq_clr,
    input  logic [LOW_W-1:0] min_cnt,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             strobe,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             strobe;
        logic             irq;
    } st_t;

    st_t              s_d, s_q;
    logic             irq_set;
    logic [CNT_W-1:0] nxt;
    logic [LOW_W-1:0] lo_nxt;

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        irq_set    = 1'b0;
        nxt        = s_q.cnt + CNT_W'(1);
        lo_nxt     = s_q.cnt[LOW_W-1:0] + LOW_W'(1);
        unique case (mode)
            MODE_IDLE: begin
                s_d.cnt  = '0;
                s_d.done = 1'b0;
            end
            MODE_FREE: begin
                if (tick) begin
                    s_d.cnt = nxt;
                    if (&s_q.cnt) irq_set = 1'b1;
                end
            end
            MODE_SLOW: begin
                if (bus_evt) begin
                    s_d.cnt  = '0;
                    s_d.done = 1'b0;
                end else if (tick) begin
                    s_d.cnt[LOW_W-1:0] = lo_nxt;
                    if (lo_nxt == min_cnt && !s_q.done) begin
                        s_d.strobe = 1'b1;
                        s_d.done   = 1'b1;
                    end
                end
            end
            MODE_BUS: begin
                if (bus_evt) begin
                    s_d.cnt  = '0;
                    s_d.done = 1'b0;
                end else if (tick) begin
                    if (nxt == limit) begin
                        s_d.cnt  = '0;
                        s_d.done = 1'b0;
                        irq_set  = 1'b1;
                    end else begin
                        s_d.cnt = nxt;
                        if (nxt[LOW_W-1:0] == min_cnt && !s_q.done) begin
                            s_d.strobe = 1'b1;
                            s_d.done   = 1'b1;
                        end
                    end
                end
            end
            default: ;
        endcase
        if (irq_set)      s_d.irq = 1'b1;
        else if (irq_clr) s_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt    = s_q.cnt;
    assign strobe = s_q.strobe;
    assign irq    = s_q.irq;
endmodule

// File: rtl/i2c_bus_timer.sv
module i2c_bus_timer
    import i2ct_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int LOW_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run_en,
    input  logic       slave_en,
    input  logic       master_req,
    input  logic       master_act,
    input  logic [1:0] period_sel,
    input  logic       scl_edge,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       irq_clr,
    output logic       min_time_done,
    output logic       timeout_irq
);
    tmode_e           mode;
    logic             bus_evt;
    logic [LOW_W-1:0] min_cnt;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_w;

    assign bus_evt = scl_edge | bus_start | bus_stop;

    i2ct_mode_dec u_mode (
        .run_en     (run_en),
        .slave_en   (slave_en),
        .master_req (master_req),
        .master_act (master_act),
        .mode       (mode)
    );

    i2ct_period_dec #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_period (
        .period_sel (period_sel),
        .min_cnt    (min_cnt),
        .limit      (limit)
    );

    i2ct_core #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mode    (mode),
        .bus_evt (bus_evt),
        .irq_clr (irq_clr),
        .min_cnt (min_cnt),
        .limit   (limit),
        .cnt     (cnt_w),
        .strobe  (min_time_done),
        .irq     (timeout_irq)
    );
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk #(
    parameter int CNT_W = 10,
    parameter int LOW_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             run_en,
    input logic             any_flag,
    input logic             bus_evt,
    input logic             irq_clr,
    input logic [CNT_W-1:0] cnt,
    input logic             strobe,
    input logic             irq
);
    // R1
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !any_flag) |=> (cnt == '0 && !strobe));

    // R2
    free_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !any_flag) |=> !strobe);

    // R3
    slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && any_flag && !bus_evt) |=> $stable(cnt[CNT_W-1:LOW_W]));

    // R6
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R7
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_flag && bus_evt) |=> (cnt == '0));

    // R8
    no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !bus_evt && (run_en || any_flag)) |=> $stable(cnt));

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
endmodule

bind i2c_bus_timer i2ct_chk #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run_en   (run_en),
    .any_flag (slave_en | master_req | master_act),
    .bus_evt  (bus_evt),
    .irq_clr  (irq_clr),
    .cnt      (cnt_w),
    .strobe   (min_time_done),
    .irq      (timeout_irq)
);

// File: tb/i2c_bus_timer_tb.sv
module i2c_bus_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       run_en = 1'b0;
    logic       slave_en = 1'b0;
    logic       master_req = 1'b0;
    logic       master_act = 1'b0;
    logic [1:0] period_sel = 2'b00;
    logic       scl_edge = 1'b0;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       irq_clr = 1'b0;
    logic       min_time_done;
    logic       timeout_irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    i2c_bus_timer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .run_en        (run_en),
        .slave_en      (slave_en),
        .master_req    (master_req),
        .master_act    (master_act),
        .period_sel    (period_sel),
        .scl_edge      (scl_edge),
        .bus_start     (bus_start),
        .bus_stop      (bus_stop),
        .irq_clr       (irq_clr),
        .min_time_done (min_time_done),
        .timeout_irq   (timeout_irq)
    );

    typedef struct packed {
        logic [1:0] sel;
        int         mn;
        int         lim;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{2'b10, 7, 1023},
        '{2'b01, 6, 1022},
        '{2'b00, 5, 1021},
        '{2'b11, 4, 1020}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic r, input logic s, input logic q, input logic a);
        @(negedge clk);
        tick = 1'b0;
        run_en = r; slave_en = s; master_req = q; master_act = a;
    endtask

    // kind: 0 scl edge, 1 start, 2 stop
    task automatic pulse_evt(input int kind, input logic with_tick);
        @(negedge clk);
        tick = with_tick;
        scl_edge  = (kind == 0);
        bus_start = (kind == 1);
        bus_stop  = (kind == 2);
        @(negedge clk);
        tick = 1'b0; scl_edge = 1'b0; bus_start = 1'b0; bus_stop = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic go_idle();
        set_mode(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        pulse_clr();
    endtask

    // Drive ticks (one every 'step' cycles) and record output events.
    task automatic measure(input int cycles, input int step,
                           output int t_str, output int t_irq, output int n_str);
        t_str = -1; t_irq = -1; n_str = 0;
        for (int c = 1; c <= cycles; c++) begin
            @(negedge clk);
            tick = ((c % step) == 0);
            @(posedge clk);
            #1;
            if (min_time_done) begin
                n_str++;
                if (t_str < 0) t_str = c;
            end
            if (timeout_irq && t_irq < 0) t_irq = c;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int ts, ti, ns;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 strobe after reset", int'(min_time_done), 0);
        chk("R10 irq after reset", int'(timeout_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 idle: nothing happens over many ticks
        measure(1500, 1, ts, ti, ns);
        chk("R1 idle strobes", ns, 0);
        chk("R1 idle irq", ti, -1);

        // R4 R5 R6 table sweep in bus mode
        foreach (VEC[i]) begin
            go_idle();
            set_mode(1'b1, 1'b1, 1'b0, 1'b0);
            period_sel = VEC[i].sel;
            pulse_evt(0, 1'b0);
            measure(1100, 1, ts, ti, ns);
            chk("R4 min-time tick", ts, VEC[i].mn);
            chk("R5 timeout tick", ti, VEC[i].lim);
            chk("R6 R5 strobe count with re-arm", ns, 2);
        end

        // R9 sticky and clear
        @(negedge clk);
        set_mode(1'b0, 1'b0, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        chk("R9 irq sticky", int'(timeout_irq), 1);
        pulse_clr();
        chk("R9 irq cleared", int'(timeout_irq), 0);

        // R2 free mode wrap
        go_idle();
        set_mode(1'b1, 1'b0, 1'b0, 1'b0);
        period_sel = 2'b11;
        measure(1100, 1, ts, ti, ns);
        chk("R2 free wrap tick", ti, 1024);
        chk("R2 free no strobe", ns, 0);

        // R3 slow mode: strobe once, never timeout
        go_idle();
        set_mode(1'b0, 1'b1, 1'b0, 1'b0);
        period_sel = 2'b00;
        measure(2100, 1, ts, ti, ns);
        chk("R3 slow min-time tick", ts, 5);
        chk("R3 R6 slow single strobe", ns, 1);
        chk("R3 slow no timeout", ti, -1);

        // R7 clear mid-count by start, then by stop with tick high
        go_idle();
        set_mode(1'b1, 1'b0, 1'b1, 1'b0);
        period_sel = 2'b11;
        pulse_evt(0, 1'b0);
        measure(3, 1, ts, ti, ns);
        chk("R7 no strobe before clear", ns, 0);
        pulse_evt(1, 1'b0);
        measure(10, 1, ts, ti, ns);
        chk("R7 start clears count", ts, 4);
        measure(2, 1, ts, ti, ns);
        pulse_evt(2, 1'b1);
        measure(10, 1, ts, ti, ns);
        chk("R7 stop wins over tick", ts, 4);
        chk("R7 R6 single strobe after clear", ns, 1);

        // R8 sparse ticks
        go_idle();
        set_mode(1'b1, 1'b0, 1'b0, 1'b1);
        period_sel = 2'b10;
        pulse_evt(0, 1'b0);
        measure(40, 3, ts, ti, ns);
        chk("R8 strobe with tick every third cycle", ts, 21);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule